// File: doc/BRIEF.md
# Switchable Memory-Map Chip-Select Decoder

This block generates the chip selects for a small 8-bit processor system with a 16-bit address bus. It takes the address, the level of the processor clock phase and the read/write strobe. It drives active-low selects for the program ROM, the data RAM and a bank of peripheral slots, and it also drives the RAM output-enable. The ROM always occupies the upper half of the address space, and that half includes the interrupt vectors at the very top. The RAM select is qualified by the high clock phase. It is never asserted for an address that has the top bit set, so a stray write into the ROM range cannot alias into low RAM.

A mode code chooses one of four memory maps, all backward compatible with each other. Baseline gives 16 KiB of RAM and one peripheral window at 0x6000. Wide RAM grows the RAM to 24 KiB and keeps the peripheral at 0x6000. Slotted splits 0x6000–0x7FFF into eight 1 KiB device slots, with slot 0 kept at 0x6000. Slotted with RAM tail hands the top two slots (0x7800–0x7FFF) to RAM. The mode is captured while reset is held and is static afterwards. While reset is asserted every select rests at its idle high level.

Top module: `memsel_decoder`

## Requirements
- R1: `rom_cs_n` is low exactly when address bit 15 is 1 (0x8000–0xFFFF, vectors 0xFFFA–0xFFFF included), in every mode, regardless of clock phase or read/write.
- R2: `ram_cs_n` is low only when `phi2_i` is 1, address bit 15 is 0 and the address lies in the current mode's RAM window; it is high whenever `phi2_i` is 0.
- R3: `ram_oe_n` is low exactly for a read (`rw_i`=1) to an address in the current RAM window, independent of clock phase; a write (`rw_i`=0) keeps it high.
- R4: Mode code 3'b001 (wide RAM): the RAM window is 0x0000–0x5FFF; `dev_cs_n[0]` is low for 0x6000–0x7FFF; the other device selects stay high.
- R5: Mode code 3'b000 (baseline): the RAM window is 0x0000–0x3FFF; `dev_cs_n[0]` is low for 0x6000–0x7FFF; 0x4000–0x5FFF selects nothing.
- R6: Mode code 3'b010 (slotted): the RAM window is 0x0000–0x5FFF; in 0x6000–0x7FFF, `dev_cs_n[k]` is low where k is address bits 12..10, so slot 0 covers 0x6000–0x63FF and slot 7 covers 0x7C00–0x7FFF.
- R7: Mode code 3'b011 (slotted with RAM tail): slots 0–5 behave as in R6 over 0x6000–0x77FF; 0x7800–0x7FFF is part of the RAM window and `dev_cs_n[7:6]` stay high.
- R8: Mode codes 3'b100 to 3'b111 behave exactly as baseline (R5).
- R9: For any address, clock level and read/write, at most one of `rom_cs_n`, `ram_cs_n` and the eight `dev_cs_n` bits is low.
- R10: While `rst_n` is 0, every select output and `ram_oe_n` is high.
- R11: The mode code is captured on clock edges only while `rst_n` is 0; changes to `mode_i` after reset is released have no effect on the map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used to capture the mode code during reset |
| rst_n | input | 1 | Active-low reset; forces all outputs idle |
| mode_i | input | 3 | Memory-map code, captured while in reset |
| phi2_i | input | 1 | Level of the processor clock phase; 1 = high phase |
| rw_i | input | 1 | Bus direction; 1 = read, 0 = write |
| addr_i | input | 16 | Processor address bus |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low, phase qualified |
| ram_oe_n | output | 1 | RAM output-enable, active low |
| dev_cs_n | output | 8 | Peripheral slot selects, active low |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge of `clk` before the decoder is used. They also assume that the address, phase and direction inputs are settled when `clk` rises, because the properties compare the combinational outputs with those inputs at the edge. The stimulus keeps to both. It holds reset for several edges with the desired mode code and then changes the bus inputs only at instants offset from every clock edge. After release it moves `mode_i` freely, because that input must then be ignored.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MAP_BASE     = 3'd0,
      MAP_WIDE     = 3'd1,
      MAP_SLOT     = 3'd2,
      MAP_SLOT_RAM = 3'd3
   } map_e;

   // Codes outside the defined set fall back to the baseline map.
   function automatic map_e to_map(input logic [MODE_W-1:0] code);
      map_e m;
      case (code)
         3'd1:    m = MAP_WIDE;
         3'd2:    m = MAP_SLOT;
         3'd3:    m = MAP_SLOT_RAM;
         default: m = MAP_BASE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/memsel_mode_latch.sv
`timescale 1ns/1ps
module memsel_mode_latch
   import memsel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   output map_e              map_o
);

   map_e map_q;

   // Mode is only written while reset is held; afterwards it is frozen.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q <= to_map(mode_i);
      end
   end

   assign map_o = map_q;

endmodule

// File: rtl/memsel_window.sv
`timescale 1ns/1ps
module memsel_window
   import memsel_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SLOTS      = 8,
   parameter int TAIL_SLOTS = 2,
   localparam int SLOT_BITS = $clog2(SLOTS),
   localparam int SLOT_MSB  = ADDR_W - 4
)(
   input  logic [ADDR_W-1:0]    addr_i,
   input  map_e                 map_i,
   output logic                 ram_win_o,
   output logic                 dev_en_o,
   output logic                 split_o,
   output logic [SLOT_BITS-1:0] slot_o
);

   localparam int TAIL_FIRST = SLOTS - TAIL_SLOTS;

   logic hi, b14, b13, io_region, low_ram, tail;
   logic [SLOT_BITS-1:0] slot;

   assign hi        = addr_i[ADDR_W-1];
   assign b14       = addr_i[ADDR_W-2];
   assign b13       = addr_i[ADDR_W-3];
   assign slot      = addr_i[SLOT_MSB -: SLOT_BITS];
   assign io_region = !hi && b14 && b13;
   assign low_ram   = !hi && !(b14 && b13);
   assign tail      = io_region && (32'(slot) >= TAIL_FIRST);

   always_comb begin
      ram_win_o = 1'b0;
      dev_en_o  = 1'b0;
      split_o   = 1'b0;
      unique case (map_i)
         MAP_WIDE: begin
            ram_win_o = low_ram;
            dev_en_o  = io_region;
         end
         MAP_SLOT: begin
            ram_win_o = low_ram;
            dev_en_o  = io_region;
            split_o   = 1'b1;
         end
         MAP_SLOT_RAM: begin
            ram_win_o = low_ram || tail;
            dev_en_o  = io_region && !tail;
            split_o   = 1'b1;
         end
         default: begin
            ram_win_o = !hi && !b14;
            dev_en_o  = io_region;
         end
      endcase
   end

   assign slot_o = slot;

endmodule

// File: rtl/memsel_slot_decode.sv
`timescale 1ns/1ps
module memsel_slot_decode #(
   parameter int SLOTS = 8,
   localparam int SLOT_BITS = $clog2(SLOTS)
)(
   input  logic                 en_i,
   input  logic                 split_i,
   input  logic [SLOT_BITS-1:0] slot_i,
   output logic [SLOTS-1:0]     sel_n_o
);

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      if (k == 0) begin : g_first
         // Slot 0 also takes the whole window when the map is not split.
         assign sel_n_o[k] = !(en_i && (!split_i || slot_i == SLOT_BITS'(k)));
      end else begin : g_rest
         assign sel_n_o[k] = !(en_i && split_i && slot_i == SLOT_BITS'(k));
      end
   end

endmodule

// File: rtl/memsel_decoder.sv
`timescale 1ns/1ps
module memsel_decoder
   import memsel_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SLOTS      = 8,
   parameter int TAIL_SLOTS = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              phi2_i,
   input  logic              rw_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              rom_cs_n,
   output logic              ram_cs_n,
   output logic              ram_oe_n,
   output logic [SLOTS-1:0]  dev_cs_n
);

   localparam int SLOT_BITS = $clog2(SLOTS);

   if (SLOTS < 2 || (1 << SLOT_BITS) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (SLOT_BITS + 3 > ADDR_W) begin : g_bad_width
      $error("address too narrow for the slot field");
   end
   if (TAIL_SLOTS < 0 || TAIL_SLOTS >= SLOTS) begin : g_bad_tail
      $error("TAIL_SLOTS must leave at least one device slot");
   end

   map_e                 map;
   logic                 ram_win, dev_en, split;
   logic [SLOT_BITS-1:0] slot;
   logic [SLOTS-1:0]     dec_n;

   memsel_mode_latch u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_i),
      .map_o  (map)
   );

   memsel_window #(
      .ADDR_W     (ADDR_W),
      .SLOTS      (SLOTS),
      .TAIL_SLOTS (TAIL_SLOTS)
   ) u_win (
      .addr_i    (addr_i),
      .map_i     (map),
      .ram_win_o (ram_win),
      .dev_en_o  (dev_en),
      .split_o   (split),
      .slot_o    (slot)
   );

   memsel_slot_decode #(
      .SLOTS (SLOTS)
   ) u_dec (
      .en_i    (dev_en),
      .split_i (split),
      .slot_i  (slot),
      .sel_n_o (dec_n)
   );

   assign rom_cs_n = !(rst_n && addr_i[ADDR_W-1]);
   assign ram_cs_n = !(rst_n && phi2_i && ram_win);
   assign ram_oe_n = !(rst_n && rw_i && ram_win);
   assign dev_cs_n = rst_n ? dec_n : '1;

endmodule

// File: rtl/memsel_checker.sv
`timescale 1ns/1ps
module memsel_checker #(
   parameter int ADDR_W = 16,
   parameter int SLOTS  = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              phi2_i,
   input logic              rw_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              rom_cs_n,
   input logic              ram_cs_n,
   input logic              ram_oe_n,
   input logic [SLOTS-1:0]  dev_cs_n
);

   assert_rom_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs_n != addr_i[ADDR_W-1]);

   assert_ram_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> (phi2_i && !addr_i[ADDR_W-1]));

   assert_oe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_oe_n |-> (rw_i && !addr_i[ADDR_W-1]));

   assert_cs_oe_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_cs_n && rw_i) |-> !ram_oe_n);

   assert_dev_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_cs_n != '1) |-> (addr_i[ADDR_W-1 -: 3] == 3'b011));

   assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~rom_cs_n, ~ram_cs_n, ~dev_cs_n}) <= 1);

   assert_idle_in_reset_R10: assert property (@(posedge clk)
      !rst_n |-> (rom_cs_n && ram_cs_n && ram_oe_n && (dev_cs_n == '1)));

endmodule

bind memsel_decoder memsel_checker #(
   .ADDR_W (ADDR_W),
   .SLOTS  (SLOTS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .phi2_i   (phi2_i),
   .rw_i     (rw_i),
   .addr_i   (addr_i),
   .rom_cs_n (rom_cs_n),
   .ram_cs_n (ram_cs_n),
   .ram_oe_n (ram_oe_n),
   .dev_cs_n (dev_cs_n)
);

// File: tb/tb_memsel_decoder.sv
`timescale 1ns/1ps
module tb_memsel_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic        phi2_i = 1'b0;
   logic        rw_i = 1'b1;
   logic [15:0] addr_i = 16'h0000;
   logic        rom_cs_n, ram_cs_n, ram_oe_n;
   logic [7:0]  dev_cs_n;

   int checks = 0;
   int fails  = 0;
   int prints = 0;
   int multi  = 0;

   memsel_decoder dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode_i),
      .phi2_i   (phi2_i),
      .rw_i     (rw_i),
      .addr_i   (addr_i),
      .rom_cs_n (rom_cs_n),
      .ram_cs_n (ram_cs_n),
      .ram_oe_n (ram_oe_n),
      .dev_cs_n (dev_cs_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Expected {rom, ram_cs, ram_oe, dev[7:0]} from the address ranges.
   function automatic logic [10:0] ref_model(int m, int a, bit ph, bit rw);
      int  mm = (m > 3) ? 0 : m;
      bit  ramwin;
      int  slot = -1;
      logic [7:0] dev = 8'hFF;
      case (mm)
         0:       ramwin = (a < 'h4000);
         1, 2:    ramwin = (a < 'h6000);
         default: ramwin = (a < 'h6000) || (a >= 'h7800 && a < 'h8000);
      endcase
      if (a >= 'h6000 && a < 'h8000 && !(mm == 3 && a >= 'h7800))
         slot = (mm >= 2) ? (a - 'h6000) / 'h400 : 0;
      if (slot >= 0) dev[slot] = 1'b0;
      return {!(a >= 'h8000), !(ramwin && ph), !(ramwin && rw), dev};
   endfunction

   task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         if (prints < 20) begin
            prints++;
            $display("FAIL %s addr=%h phi2=%0b rw=%0b actual=%b expected=%b",
                     tag, addr_i, phi2_i, rw_i, act, exp);
         end
      end
   endtask

   // Drives one bus state, samples half a step later, away from clk edges.
   task automatic probe(string tag, int m, int a, bit ph, bit rw);
      logic [10:0] act;
      addr_i = 16'(a);
      phi2_i = ph;
      rw_i   = rw;
      #0.5;
      act = {rom_cs_n, ram_cs_n, ram_oe_n, dev_cs_n};
      if ($countones(~act[10:9]) + $countones(~act[7:0]) > 1) multi++;
      check(tag, act, ref_model(m, a, ph, rw));
      #0.5;
   endtask

   task automatic start_mode(int m);
      rst_n  = 1'b0;
      mode_i = 3'(m);
      repeat (3) @(posedge clk);
      #1.25;
      // R10: idle while reset is held, whatever the bus shows.
      addr_i = 16'h0000; phi2_i = 1'b1; rw_i = 1'b1;
      #0.5; check("R10", {rom_cs_n, ram_cs_n, ram_oe_n, dev_cs_n}, 11'h7FF); #0.5;
      addr_i = 16'hFFFF;
      #0.5; check("R10", {rom_cs_n, ram_cs_n, ram_oe_n, dev_cs_n}, 11'h7FF); #0.5;
      addr_i = 16'h6000;
      #0.5; check("R10", {rom_cs_n, ram_cs_n, ram_oe_n, dev_cs_n}, 11'h7FF); #0.5;
      @(posedge clk);
      #1.25;
      rst_n = 1'b1;
      @(posedge clk);
      #0.25;
   endtask

   function automatic string mode_tag(int m);
      case (m)
         0:       return "R5";
         1:       return "R4";
         2:       return "R6";
         3:       return "R7";
         default: return "R8";
      endcase
   endfunction

   initial begin
      for (int m = 0; m < 8; m++) begin
         int stride = (m < 4) ? 1 : 7;
         start_mode(m);
         for (int a = 0; a < 65536; a += stride) begin
            probe(mode_tag(m), m, a, 1'b0, bit'(a[0] ^ a[7]));
            probe(mode_tag(m), m, a, 1'b1, bit'(a[1] ^ a[9]));
         end
      end

      // Boundary and named cases.
      start_mode(0);
      probe("R1", 0, 'hFFFA, 1'b0, 1'b1);
      probe("R1", 0, 'h8000, 1'b1, 1'b0);
      probe("R2", 0, 'h1234, 1'b0, 1'b1);
      probe("R2", 0, 'h9000, 1'b1, 1'b0);
      probe("R3", 0, 'h3FFF, 1'b1, 1'b0);
      probe("R3", 0, 'h3FFF, 1'b0, 1'b1);
      probe("R5", 0, 'h4000, 1'b1, 1'b1);
      probe("R5", 0, 'h7FFF, 1'b1, 1'b1);

      start_mode(1);
      probe("R4", 1, 'h5FFF, 1'b1, 1'b1);
      probe("R4", 1, 'h6000, 1'b1, 1'b1);
      probe("R4", 1, 'h7C00, 1'b1, 1'b1);

      start_mode(2);
      probe("R6", 2, 'h63FF, 1'b1, 1'b1);
      probe("R6", 2, 'h6400, 1'b1, 1'b1);
      probe("R6", 2, 'h7FFF, 1'b1, 1'b1);

      start_mode(3);
      probe("R7", 3, 'h77FF, 1'b1, 1'b1);
      probe("R7", 3, 'h7800, 1'b1, 1'b1);
      probe("R7", 3, 'h7FFF, 1'b0, 1'b1);

      start_mode(5);
      probe("R8", 5, 'h5000, 1'b1, 1'b1);
      probe("R8", 5, 'h6400, 1'b1, 1'b1);

      // R11: mode changes after reset release are ignored.
      start_mode(1);
      mode_i = 3'd0;
      repeat (2) @(posedge clk);
      #0.25;
      probe("R11", 1, 'h4000, 1'b1, 1'b1);
      mode_i = 3'd2;
      repeat (2) @(posedge clk);
      #0.25;
      probe("R11", 1, 'h6400, 1'b1, 1'b1);

      // R9: aggregated exclusivity over everything probed.
      checks++;
      if (multi != 0) begin
         fails++;
         $display("FAIL R9 vectors with several selects: actual=%0d expected=0", multi);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule